// File: doc/BRIEF.md
# I2C Register-File Target

This block is a byte-oriented I2C target with a small register file behind it. A fast system clock samples SCL and SDA after a two-flop synchronizer. The block finds START, repeated START and STOP conditions on the synchronized lines. Its 7-bit address is the fixed prefix `11110` followed by two strap inputs, with the upper strap as the more significant bit. SDA is open-drain: the single output `sda_oe` pulls the line low when it is 1, and an external pull-up holds the line high otherwise.

In a write, the byte after the address sets an internal pointer. Each following byte is stored at that pointer. In a read, the block shifts out the register at the pointer until the host answers a byte with a not-acknowledge. The pointer steps by one after every data byte, in either direction, and wraps from the last register to register 0. Local logic sees the whole register file through a combinational read port.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset `sda_oe` is 0 and every register reads 0 on the local port.
- R2: An address byte whose upper seven bits equal `11110`,`strap[1]`,`strap[0]` (MSB first, R/W in bit 0) is acknowledged. `sda_oe` stays 1 for the whole high phase of the 9th SCL pulse.
- R3: After an address byte that does not match, the block never asserts `sda_oe`, and it stores nothing until the next START or STOP.
- R4: In a write (R/W=0), the first byte after the address loads the pointer from its low bits. Each following byte is stored at the pointer and can be read on `rd_data` at `rd_addr`.
- R5: The pointer advances by one after each data byte written or read, and wraps from 15 to 0.
- R6: In a read (R/W=1), the block drives the register at the pointer MSB first. It changes SDA only while SCL is low, and each byte the host acknowledges is followed by the next register.
- R7: When the host does not acknowledge a read byte, the block releases SDA and keeps it released until the next START or STOP.
- R8: A repeated START ends the current transfer and restarts address matching, so a pointer write can be followed by a read without a STOP in between.
- R9: A STOP at any bit position returns the block to idle. A partly received data byte is discarded.
- R10: A STOP in the same SCL high phase as the START is ignored, and the transaction that follows proceeds.
- R11: `sda_oe` is never newly asserted while the synchronized SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of host and target) |
| strap | input | 2 | Low two address bits |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | input | 4 | Local register read index |
| rd_data | output | 8 | Register contents at `rd_addr` |

## Verification
Two functions can fall in the same cycle. A bus condition (START or STOP) can be seen in the very cycle the bit engine would otherwise shift or store, and a STOP can arrive inside the high phase that opened with a START. The bench provokes the first case by issuing a STOP partway through a data byte and by issuing a repeated START straight after an acknowledged pointer byte. It provokes the second by raising SDA again before SCL falls after a START. In each case it judges the outcome only through the register port and the acknowledge and data bits seen on the line.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [4:0] PREFIX = 5'b11110,
  parameter int NREGS = 16,
  localparam int PW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap,
  output logic          sda_oe,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WDATA, S_RDATA, S_SKIP} st_t;

  st_t          state;
  logic [2:0]   scl_sy, sda_sy;
  logic [3:0]   cnt;
  logic [7:0]   sreg, tx;
  logic [PW-1:0] ptr;
  logic         rw, nack, start_hi;
  logic [7:0]   regs [NREGS];

  wire scl_s = scl_sy[1], scl_q = scl_sy[2];
  wire sda_s = sda_sy[1], sda_q = sda_sy[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s & ~start_hi;
  wire rx       = (state == S_ADDR) || (state == S_PTR) || (state == S_WDATA);
  wire active   = rx || (state == S_RDATA);
  wire addr_hit = sreg[7:1] == {PREFIX, strap};
  wire ack_fall = scl_fall && cnt == 4'd8;
  wire end_fall = scl_fall && cnt == 4'd9;
  wire ptr_load = active && ack_fall && state == S_PTR;

  assign rd_data = regs[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      sreg <= '0;
      tx <= '0;
      ptr <= '0;
      rw <= 1'b0;
      nack <= 1'b0;
      start_hi <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (start_c) begin
      state <= S_ADDR;
      cnt <= '0;
      sda_oe <= 1'b0;
      start_hi <= 1'b1;
    end else if (stop_c) begin
      state <= S_IDLE;
      cnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (scl_fall) start_hi <= 1'b0;
      if (active) begin
        if (scl_rise && cnt != 4'd9) cnt <= cnt + 4'd1;
        if (scl_rise && rx && cnt < 4'd8) sreg <= {sreg[6:0], sda_s};
        if (scl_rise && cnt == 4'd8 && state == S_RDATA) begin
          ptr  <= ptr + 1'b1;
          nack <= sda_s;
        end
        if (ack_fall) begin
          case (state)
            S_ADDR:  if (addr_hit) begin sda_oe <= 1'b1; rw <= sreg[0]; end
                     else state <= S_SKIP;
            S_PTR:   begin ptr <= sreg[PW-1:0]; sda_oe <= 1'b1; end
            S_WDATA: begin regs[ptr] <= sreg; ptr <= ptr + 1'b1; sda_oe <= 1'b1; end
            default: sda_oe <= 1'b0;
          endcase
        end
        if (scl_fall && state == S_RDATA && cnt >= 4'd1 && cnt <= 4'd7) begin
          tx <= tx << 1;
          sda_oe <= ~tx[6];
        end
        if (end_fall) begin
          cnt <= '0;
          sda_oe <= 1'b0;
          if ((state == S_ADDR && rw) || (state == S_RDATA && !nack)) begin
            state <= S_RDATA;
            tx <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
          end else if (state == S_RDATA) state <= S_SKIP;
          else if (state == S_ADDR) state <= S_PTR;
          else if (state == S_PTR) state <= S_WDATA;
        end
      end
    end
  end

  assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx && cnt == 4'd9) |-> sda_oe);
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe);
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && !$past(ptr_load)) |-> (ptr == PW'($past(ptr) + 1'b1)));
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE && !sda_oe));
  assert_no_drive_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;
  localparam int Q = 12;
  logic clk = 0, rst_n = 0, scl = 1, sda_h = 1;
  logic [1:0] strap = 2'b10;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic sda_oe;
  wire sda_line = sda_h & ~sda_oe;
  int checks = 0, errors = 0, oe_cnt = 0, r11_bad = 0;
  logic scl_p = 1, oe_p = 0;
  logic [8:0] exp_q[$], act_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  i2c_regfile_target dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap(strap), .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(negedge clk) begin
    if (sda_oe) oe_cnt++;
    if (scl && scl_p && sda_oe && !oe_p) r11_bad++;
    scl_p <= scl; oe_p <= sda_oe;
  end

  task automatic expect_v(string tag, logic [8:0] e); tag_q.push_back(tag); exp_q.push_back(e); endtask
  task automatic observe(logic [8:0] a); act_q.push_back(a); endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [8:0] a = act_q.pop_front();
      automatic logic [8:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      checks++;
      if (a !== e) begin errors++; $display("FAIL %s actual=%0h expected=%0h", t, a, e); end
    end
  end

  task automatic hold(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start; sda_h = 1; hold(Q); scl = 1; hold(Q); sda_h = 0; hold(Q); scl = 0; hold(Q); endtask
  task automatic bus_stop; sda_h = 0; hold(Q); scl = 1; hold(Q); sda_h = 1; hold(Q); endtask
  task automatic clk_bit(input logic b, output logic seen);
    sda_h = b; hold(Q); scl = 1; hold(Q/2); seen = sda_line; hold(Q/2); scl = 0; hold(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s); ack = ~s;
  endtask
  task automatic read_byte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~host_ack, s);
  endtask
  task automatic port(string tag, int a, logic [7:0] e);
    rd_addr = a[3:0]; hold(1); expect_v(tag, {1'b0, e}); observe({1'b0, rd_data});
  endtask

  initial begin
    logic ack; logic [7:0] d;
    hold(4); rst_n = 1; hold(4);
    expect_v("R1 oe", 0); observe({8'b0, sda_oe});
    port("R1 reg5", 5, 8'h00);

    bus_start; send_byte(8'hF4, ack); expect_v("R2 ack", 1); observe({8'b0, ack});
    send_byte(8'h03, ack); send_byte(8'hA5, ack); send_byte(8'h3C, ack); bus_stop;
    port("R4 reg3", 3, 8'hA5); port("R4 reg4", 4, 8'h3C);

    bus_start; send_byte(8'hF4, ack); send_byte(8'h0F, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); bus_stop;
    port("R5 reg15", 15, 8'h11); port("R5 wrap reg0", 0, 8'h22);

    bus_start; send_byte(8'hF4, ack); send_byte(8'h03, ack);
    bus_start; send_byte(8'hF5, ack); expect_v("R8 read ack after Sr", 1); observe({8'b0, ack});
    read_byte(1, d); expect_v("R6 byte0", 9'hA5); observe({1'b0, d});
    read_byte(0, d); expect_v("R6 byte1", 9'h3C); observe({1'b0, d});
    oe_cnt = 0; read_byte(1, d); expect_v("R7 released", 0); observe(9'(oe_cnt));
    bus_stop;

    bus_start; send_byte(8'hF4, ack); send_byte(8'h0F, ack); bus_start; send_byte(8'hF5, ack);
    read_byte(1, d); expect_v("R5 read reg15", 9'h11); observe({1'b0, d});
    read_byte(0, d); expect_v("R5 read wrap", 9'h22); observe({1'b0, d});
    bus_stop;

    oe_cnt = 0;
    bus_start; send_byte(8'hF6, ack); send_byte(8'h02, ack); send_byte(8'h99, ack); bus_stop;
    expect_v("R3 no drive", 0); observe(9'(oe_cnt));
    port("R3 reg2", 2, 8'h00);

    bus_start; send_byte(8'hF4, ack); send_byte(8'h07, ack);
    for (int i = 0; i < 4; i++) clk_bit(i[0] ? 1'b0 : 1'b1, ack);
    scl = 0; bus_stop;
    oe_cnt = 0;
    for (int i = 0; i < 5; i++) clk_bit(1'b0, ack);
    hold(Q); scl = 1; sda_h = 1; hold(Q);
    expect_v("R9 idle no drive", 0); observe(9'(oe_cnt));
    port("R9 reg7", 7, 8'h00);

    sda_h = 1; scl = 1; hold(Q); sda_h = 0; hold(Q); sda_h = 1; hold(Q); scl = 0; hold(Q);
    send_byte(8'hF4, ack); expect_v("R10 ack", 1); observe({8'b0, ack});
    send_byte(8'h08, ack); send_byte(8'h5A, ack); bus_stop;
    port("R10 reg8", 8, 8'h5A);

    strap = 2'b11;
    bus_start; send_byte(8'hF6, ack); expect_v("R2 strap ack", 1); observe({8'b0, ack});
    send_byte(8'h09, ack); send_byte(8'hC3, ack); bus_stop;
    port("R2 reg9", 9, 8'hC3);

    expect_v("R11 no rise while SCL high", 0); observe(9'(r11_bad));
    hold(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule